// File: doc/BRIEF.md
# Dark-Current Calibration Search Engine

This block finds, for each of several detector channels in parallel, the calibration DAC code that cancels the detector's dark current. With that code applied, the unilluminated integrator output sits as close to zero as the hardware allows. Each trial code costs one full integrate-and-convert cycle, so the engine spends as few trials as it can. Binary halving is not reliable here, because a saturated amplifier gives no usable magnitude. The engine instead works in two phases. While a channel reads saturated, it moves that channel's code by one ADC full-scale span, in the direction the saturation points. As soon as the channel reads in range, it sets the final code in one correction step computed from that reading.

A run starts with a pulse on `start`. The engine captures the fault bitmap at that moment. It then offers one set of trial codes at a time to the acquisition sequencer and waits for the matching set of samples. When every channel has settled, failed or been skipped, it presents the codes and the failure flags for the per-pixel calibration table. All three exchanges are valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. Once raised, a valid stays high and its payload stays unchanged until the transfer happens. Ready may be held low for any number of cycles. At most one of `trial_valid`, `smp_ready` and `res_valid` is high at any time, so there is only ever one trial in flight. The defaults are 8 channels, a 12-bit DAC, a 16-bit ADC, an ADC-to-DAC scale shift of 8 (a coarse step of 256 codes), a limit of 16 coarse steps and a start code of 2000.

Top module: `cal_search`

## Requirements
- R1: A `start` pulse while `busy` is low begins a run: `busy` is high from the next cycle until the results transfer, after which it is low again. A `start` pulse during a run has no effect on the codes, the flags or the number of trials.
- R2: On the first trial of a run, every channel whose `fault_mask` bit was 0 at start presents code START_CODE (2000).
- R3: A searching channel whose sample is flagged saturated moves its code by 256. It moves up if the sample's sign bit is 0 and down if the sign bit is 1. The result is clamped to 0..4095, so it never wraps.
- R4: A searching channel whose sample is not saturated gets the final code: its current code plus the sample arithmetically shifted right by 8, clamped to 0..4095. The code then stays unchanged for the rest of the run.
- R5: A channel whose `fault_mask` bit was 1 at start presents code 0 on every trial and in the result, and its failure flag is 0. Changes on `fault_mask` after start have no effect on the run.
- R6: A searching channel that reads saturated after it has already taken 16 coarse steps gets `res_fail` set and keeps its last code.
- R7: Trials repeat while at least one channel is still searching. The result is offered right after the sample that resolves the last channel, so the trial count equals the largest number of trials any channel needed. If all channels are masked, the result follows without any trial.
- R8: The trial and result payloads stay stable while their valid is high and ready is low. `smp_ready` is high only while one trial's samples are awaited, and it drops after one sample transfer.
- R9: At most one of `trial_valid`, `smp_ready`, `res_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| fault_mask | input | NCH | Channels to skip, captured at start |
| busy | output | 1 | A run is in progress |
| trial_valid | output | 1 | Trial codes on `cal_code` are offered |
| trial_ready | input | 1 | Sequencer accepts the trial |
| smp_valid | input | 1 | Samples for the accepted trial are present |
| smp_ready | output | 1 | Engine awaits samples |
| smp_data | input | NCH*ADC_W | Signed samples, channel 0 in the low bits |
| smp_sat | input | NCH | Per-channel saturation flags |
| res_valid | output | 1 | Final codes and flags are offered |
| res_ready | input | 1 | Calibration table accepts the result |
| cal_code | output | NCH*DAC_W | Trial codes, or final codes while `res_valid` is high |
| res_fail | output | NCH | Per-channel calibration failure flag |

## Verification
The properties assume that the sequencer obeys the handshake: it returns exactly one sample set per accepted trial, and it raises `smp_valid` only after the trial it belongs to has transferred. They also assume that `start` is only meaningful while idle. The stimulus models a sequencer and a row of detectors. Each detector has a hidden balancing code, a small positive noise term and an optional stuck-saturated fault. The bench raises `smp_valid` only after each trial transfer, and it puts random stall cycles on every ready and valid. Directed runs cover clamping at both code limits, an all-masked row, a stuck channel that runs out of steps, and a stray `start` during a run.

// File: rtl/cal_search_pkg.sv
package cal_search_pkg;
  typedef enum logic [1:0] {
    CH_SRCH = 2'd0,
    CH_DONE = 2'd1,
    CH_FAIL = 2'd2,
    CH_SKIP = 2'd3
  } ch_st_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_TRIAL = 2'd1,
    S_WAIT  = 2'd2,
    S_RES   = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/cal_chan.sv
module cal_chan
  import cal_search_pkg::*;
#(
  parameter int DAC_W      = 12,
  parameter int ADC_W      = 16,
  parameter int LSB_SHIFT  = 8,
  parameter int MAX_STEPS  = 16,
  parameter int START_CODE = 2000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    fault,
  input  logic                    upd,
  input  logic signed [ADC_W-1:0] sample,
  input  logic                    sat,
  output logic [DAC_W-1:0]        code,
  output ch_st_e                  st,
  output logic                    srch_nxt
);
  localparam int SW     = $clog2(MAX_STEPS + 1);
  localparam int COARSE = 1 << (ADC_W - LSB_SHIFT);
  localparam int XW     = DAC_W + 2;
  localparam logic signed [XW-1:0] STEP_S = XW'(COARSE);
  localparam logic signed [XW-1:0] MAX_S  = XW'((1 << DAC_W) - 1);

  logic [SW-1:0]          steps, steps_n;
  logic [DAC_W-1:0]       code_n, clamped;
  ch_st_e                 st_n;
  logic signed [XW-1:0]   code_s, delta, cand;

  always_comb begin
    code_s = $signed({2'b00, code});
    if (sat) delta = sample[ADC_W-1] ? -STEP_S : STEP_S;
    else     delta = XW'(sample >>> LSB_SHIFT);
    cand = code_s + delta;
    if (cand < 0)          clamped = '0;
    else if (cand > MAX_S) clamped = MAX_S[DAC_W-1:0];
    else                   clamped = cand[DAC_W-1:0];
  end

  always_comb begin
    code_n  = code;
    st_n    = st;
    steps_n = steps;
    if (load) begin
      steps_n = '0;
      if (fault) begin
        code_n = '0;
        st_n   = CH_SKIP;
      end else begin
        code_n = DAC_W'(START_CODE);
        st_n   = CH_SRCH;
      end
    end else if (upd && st == CH_SRCH) begin
      if (sat) begin
        if (steps == SW'(MAX_STEPS)) begin
          st_n = CH_FAIL;
        end else begin
          code_n  = clamped;
          steps_n = steps + 1'b1;
        end
      end else begin
        code_n = clamped;
        st_n   = CH_DONE;
      end
    end
  end

  assign srch_nxt = (st_n == CH_SRCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= '0;
      st    <= CH_SKIP;
      steps <= '0;
    end else begin
      code  <= code_n;
      st    <= st_n;
      steps <= steps_n;
    end
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_search_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic trial_ready,
  input  logic smp_valid,
  input  logic res_ready,
  input  logic any_srch_nxt,
  output logic load,
  output logic upd,
  output logic trial_valid,
  output logic smp_ready,
  output logic res_valid,
  output logic busy
);
  ctl_st_e state, state_n;

  assign load        = (state == S_IDLE) && start;
  assign upd         = (state == S_WAIT) && smp_valid;
  assign trial_valid = (state == S_TRIAL);
  assign smp_ready   = (state == S_WAIT);
  assign res_valid   = (state == S_RES);
  assign busy        = (state != S_IDLE);

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:  if (start) state_n = any_srch_nxt ? S_TRIAL : S_RES;
      S_TRIAL: if (trial_ready) state_n = S_WAIT;
      S_WAIT:  if (smp_valid) state_n = any_srch_nxt ? S_TRIAL : S_RES;
      S_RES:   if (res_ready) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_n;
  end
endmodule

// File: rtl/cal_search.sv
module cal_search
  import cal_search_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DAC_W      = 12,
  parameter int ADC_W      = 16,
  parameter int LSB_SHIFT  = 8,
  parameter int MAX_STEPS  = 16,
  parameter int START_CODE = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NCH-1:0]         fault_mask,
  output logic                   busy,
  output logic                   trial_valid,
  input  logic                   trial_ready,
  input  logic                   smp_valid,
  output logic                   smp_ready,
  input  logic [NCH*ADC_W-1:0]   smp_data,
  input  logic [NCH-1:0]         smp_sat,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [NCH*DAC_W-1:0]   cal_code,
  output logic [NCH-1:0]         res_fail
);
  logic           load, upd;
  logic [NCH-1:0] srch_nxt;
  ch_st_e         st [NCH];

  cal_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .trial_ready  (trial_ready),
    .smp_valid    (smp_valid),
    .res_ready    (res_ready),
    .any_srch_nxt (|srch_nxt),
    .load         (load),
    .upd          (upd),
    .trial_valid  (trial_valid),
    .smp_ready    (smp_ready),
    .res_valid    (res_valid),
    .busy         (busy)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cal_chan #(
      .DAC_W      (DAC_W),
      .ADC_W      (ADC_W),
      .LSB_SHIFT  (LSB_SHIFT),
      .MAX_STEPS  (MAX_STEPS),
      .START_CODE (START_CODE)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .fault    (fault_mask[i]),
      .upd      (upd),
      .sample   ($signed(smp_data[i*ADC_W +: ADC_W])),
      .sat      (smp_sat[i]),
      .code     (cal_code[i*DAC_W +: DAC_W]),
      .st       (st[i]),
      .srch_nxt (srch_nxt[i])
    );
    assign res_fail[i] = (st[i] == CH_FAIL);
  end
endmodule

// File: rtl/cal_search_chk.sv
module cal_search_chk #(
  parameter int NCH        = 8,
  parameter int DAC_W      = 12,
  parameter int ADC_W      = 16,
  parameter int LSB_SHIFT  = 8,
  parameter int MAX_STEPS  = 16,
  parameter int START_CODE = 2000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [NCH-1:0]       fault_mask,
  input logic                 busy,
  input logic                 trial_valid,
  input logic                 trial_ready,
  input logic                 smp_valid,
  input logic                 smp_ready,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [NCH*DAC_W-1:0] cal_code,
  input logic [NCH-1:0]       res_fail
);
  localparam int CW = $clog2(MAX_STEPS + 2) + 1;

  logic [NCH-1:0] cap_mask, zero_code;
  logic [CW-1:0]  trials;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_mask <= '0;
      trials   <= '0;
    end else if (start && !busy) begin
      cap_mask <= fault_mask;
      trials   <= '0;
    end else if (trial_valid && trial_ready) begin
      trials   <= trials + 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_z
    assign zero_code[i] = (cal_code[i*DAC_W +: DAC_W] == '0);
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                          // R1
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_valid || res_valid) |-> ((cap_mask & ~zero_code) == '0));     // R5
  AST_MASKED_NOFAIL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((cap_mask & res_fail) == '0));                        // R5
  AST_TRIAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_valid && trial_ready) |-> (trials < CW'(MAX_STEPS + 1)));     // R7
  AST_TRIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_valid && !trial_ready) |=> (trial_valid && $stable(cal_code))); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(cal_code) && $stable(res_fail)));            // R8
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);                            // R8
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trial_valid, smp_ready, res_valid}));                      // R9
endmodule

bind cal_search cal_search_chk #(
  .NCH        (NCH),
  .DAC_W      (DAC_W),
  .ADC_W      (ADC_W),
  .LSB_SHIFT  (LSB_SHIFT),
  .MAX_STEPS  (MAX_STEPS),
  .START_CODE (START_CODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .fault_mask  (fault_mask),
  .busy        (busy),
  .trial_valid (trial_valid),
  .trial_ready (trial_ready),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .cal_code    (cal_code),
  .res_fail    (res_fail)
);

// File: tb/cal_search_tb_top.sv
`timescale 1ns/1ps
module cal_search_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int AW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NCH-1:0]    fault_mask = '0;
  logic              busy, trial_valid, smp_ready, res_valid;
  logic              trial_ready = 1'b0;
  logic              smp_valid = 1'b0;
  logic              res_ready = 1'b0;
  logic [NCH*AW-1:0] smp_data = '0;
  logic [NCH-1:0]    smp_sat = '0;
  logic [NCH*DW-1:0] cal_code;
  logic [NCH-1:0]    res_fail;

  always #2 clk = ~clk;

  cal_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_mask(fault_mask),
    .busy(busy), .trial_valid(trial_valid), .trial_ready(trial_ready),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .smp_sat(smp_sat), .res_valid(res_valid), .res_ready(res_ready),
    .cal_code(cal_code), .res_fail(res_fail)
  );

  int n_chk = 0;
  int n_bad = 0;

  // detector row model and requirement-level reference state
  int tgt   [NCH];
  int noise [NCH];
  bit stuck [NCH];
  bit msk   [NCH];
  int rc    [NCH];
  int rstep [NCH];
  int rst_s [NCH];   // 0 searching, 1 done, 2 failed, 3 skipped
  int pd    [NCH];
  bit ps    [NCH];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp12(input int v);
    if (v < 0) return 0;
    if (v > 4095) return 4095;
    return v;
  endfunction

  function automatic logic [NCH*DW-1:0] exp_bus();
    logic [NCH*DW-1:0] b;
    for (int i = 0; i < NCH; i++) b[i*DW +: DW] = rc[i][DW-1:0];
    return b;
  endfunction

  function automatic logic [NCH-1:0] exp_fail();
    logic [NCH-1:0] f;
    for (int i = 0; i < NCH; i++) f[i] = (rst_s[i] == 2);
    return f;
  endfunction

  function automatic bit any_srch();
    for (int i = 0; i < NCH; i++) if (rst_s[i] == 0) return 1'b1;
    return 1'b0;
  endfunction

  // detector output: higher code pulls the output down, 256 ADC LSB per DAC LSB
  task automatic plant();
    for (int i = 0; i < NCH; i++) begin
      int v;
      v = stuck[i] ? 40000 : (tgt[i] - rc[i]) * 256 + noise[i];
      if (v > 32767) begin pd[i] = 32767; ps[i] = 1'b1; end
      else if (v < -32768) begin pd[i] = -32768; ps[i] = 1'b1; end
      else begin pd[i] = v; ps[i] = 1'b0; end
    end
  endtask

  task automatic ref_step();
    for (int i = 0; i < NCH; i++) begin
      if (rst_s[i] == 0) begin
        if (ps[i]) begin
          if (rstep[i] == 16) rst_s[i] = 2;                         // R6
          else begin
            rc[i] = clamp12(rc[i] + ((pd[i] < 0) ? -256 : 256));    // R3
            rstep[i]++;
          end
        end else begin
          rc[i] = clamp12(rc[i] + (pd[i] >>> 8));                   // R4
          rst_s[i] = 1;
        end
      end
    end
  endtask

  task automatic run_case(input string name, input bit stray_start);
    int ntr;
    logic [NCH*DW-1:0] hold;
    logic [NCH-1:0] hf;
    bit stray_done;
    ntr = 0;
    stray_done = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      fault_mask[i] = msk[i];
      rstep[i] = 0;
      if (msk[i]) begin rc[i] = 0; rst_s[i] = 3; end
      else        begin rc[i] = 2000; rst_s[i] = 0; end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    fault_mask = NCH'($urandom);                                    // R5: ignored now
    check(busy == 1'b1, "R1", {name, " busy after start"}, busy, 1);
    while (any_srch() && ntr < 40) begin
      while (!trial_valid) @(negedge clk);
      ntr++;
      check(cal_code == exp_bus(), (ntr == 1) ? "R2" : "R3",
            {name, " trial codes"}, cal_code, exp_bus());
      hold = cal_code;
      repeat ($urandom_range(0, 3)) begin
        if (stray_start && !stray_done) begin start = 1'b1; stray_done = 1'b1; end
        @(negedge clk);
        start = 1'b0;
        check(trial_valid && cal_code == hold, "R8", {name, " trial hold"},
              cal_code, hold);
      end
      trial_ready = 1'b1;
      @(negedge clk);
      trial_ready = 1'b0;
      plant();
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        check(smp_ready && !trial_valid && !res_valid, "R9",
              {name, " awaiting samples"},
              {trial_valid, smp_ready, res_valid}, 3'b010);
      end
      for (int i = 0; i < NCH; i++) begin
        smp_data[i*AW +: AW] = pd[i][AW-1:0];
        smp_sat[i] = ps[i];
      end
      smp_valid = 1'b1;
      check(smp_ready == 1'b1, "R8", {name, " smp_ready"}, smp_ready, 1);
      @(negedge clk);
      smp_valid = 1'b0;
      ref_step();
      check(smp_ready == 1'b0, "R8", {name, " smp_ready drop"}, smp_ready, 0);
    end
    begin
      int w;
      w = 0;
      while (!res_valid && w < 50) begin @(negedge clk); w++; end
    end
    check(res_valid == 1'b1, "R7", {name, " result offered"}, res_valid, 1);
    check(cal_code == exp_bus(), "R4", {name, " final codes"}, cal_code, exp_bus());
    check(res_fail == exp_fail(), "R6", {name, " fail flags"}, res_fail, exp_fail());
    hold = cal_code;
    hf = res_fail;
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      check(res_valid && cal_code == hold && res_fail == hf, "R8",
            {name, " result hold"}, cal_code, hold);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(busy == 1'b0, "R1", {name, " idle after result"}, busy, 0);
  endtask

  task automatic set_row(input int t, input bit m);
    for (int i = 0; i < NCH; i++) begin
      tgt[i] = t; noise[i] = 0; stuck[i] = 1'b0; msk[i] = m;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, trial_valid, smp_ready, res_valid} == 4'b0, "R9", "reset state",
          {busy, trial_valid, smp_ready, res_valid}, 0);

    // balanced at start code: one trial
    set_row(2000, 1'b0);
    run_case("balanced", 1'b0);

    // clamping at both limits, masked channels, stray start
    set_row(1000, 1'b0);
    tgt[0] = 0; tgt[1] = 4095; tgt[3] = 2200; noise[3] = 255;
    msk[2] = 1'b1; msk[5] = 1'b1;
    run_case("limits", 1'b1);

    // stuck channel runs out of coarse steps
    set_row(3000, 1'b0);
    stuck[3] = 1'b1; tgt[6] = 50;
    run_case("stuck", 1'b0);

    // every channel masked
    set_row(0, 1'b1);
    run_case("allmask", 1'b0);

    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < NCH; i++) begin
        tgt[i]   = $urandom_range(0, 4095);
        noise[i] = $urandom_range(0, 255);
        msk[i]   = ($urandom_range(0, 7) == 0);
        stuck[i] = ($urandom_range(0, 15) == 0);
      end
      run_case("random", k[0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule